// File: doc/BRIEF.md
# Branch Redirect and Flush Controller

This block owns the fetch program counter of a six-stage in-order pipeline that predicts every branch as not taken. While nothing redirects it, the fetch address moves forward by one 32-bit instruction (4 bytes) on each clock. A held fetch is the exception: a load-use stall from the interlock freezes the address for that cycle.

Branches are resolved late. The ALU stage computes the condition and the target, and both travel with the branch into the memory stage. When the branch in the memory stage is valid and taken, the controller does three things. It loads the target into the fetch PC on the next edge. In the same cycle it raises one flush line for each of the four younger stages: fetch, decode, register read and ALU. It also adds four to a running penalty counter. The flushed stages keep moving, but each one clears its own valid bit, so it makes no register write and no memory write. A branch that is not taken costs nothing.

A redirect takes priority over a stall that is asserted in the same cycle.

Top module: `branch_redirect_ctrl`

## Requirements
- R1: During and after reset, `pc_o` equals the parameter `RESET_PC`, `penalty_o` is zero and `flush_o` is all zero.
- R2: When no taken branch is present and `stall_i` is low, `pc_o` increases by 4, modulo 2^AW, on each clock.
- R3: When `stall_i` is high and no taken branch is present, `pc_o` holds its value across the clock.
- R4: When `br_valid_i` and `br_taken_i` are both high, `pc_o` equals the sampled `br_target_i` after the next clock.
- R5: In every cycle where `br_valid_i` and `br_taken_i` are both high, all four bits of `flush_o` are high. Bit 0 flushes fetch, bit 1 flushes decode, bit 2 flushes register read and bit 3 flushes ALU. The flush is combinational from the inputs, in the same cycle.
- R6: A valid branch that is not taken raises no bit of `flush_o`, and it leaves `penalty_o` unchanged.
- R7: A taken branch and a high `stall_i` in the same cycle load the target; the stall has no effect.
- R8: Each taken branch adds exactly 4 to `penalty_o`, modulo 2^CW. Every other cycle leaves `penalty_o` unchanged.
- R9: While `br_valid_i` is low, `br_taken_i` and `br_target_i` have no effect on `pc_o`, `flush_o` or `penalty_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 1 | Load-use stall request from the interlock |
| br_valid_i | input | 1 | A branch occupies the memory stage |
| br_taken_i | input | 1 | Resolved condition of that branch |
| br_target_i | input | AW | Resolved target address of that branch |
| pc_o | output | AW | Fetch program counter |
| flush_o | output | 4 | Flush lines, bit 0 fetch through bit 3 ALU |
| penalty_o | output | CW | Running count of squashed penalty cycles |

## Verification
The bench aims at four corner cases.

- A taken branch together with a stall. A design that let the stall win would keep the old PC and drop the redirect.
- A not-taken branch. A design that flushed on the valid flag alone would squash four good instructions and charge a penalty.
- A set taken flag with the valid flag low. A design that ignored the valid flag would redirect on stale data.
- Back-to-back taken branches, plus a PC near the top of the address space. An off-by-one in the counter, or an increment that does not wrap, shows up as a wrong PC or a penalty that is not a multiple of four per branch.

// File: rtl/brc_pkg.sv
package brc_pkg;
   localparam int unsigned NUM_FLUSH   = 4;
   localparam int unsigned INSTR_BYTES = 4;

   typedef enum logic [1:0] {
      SEL_SEQ  = 2'd0,
      SEL_HOLD = 2'd1,
      SEL_TGT  = 2'd2
   } pc_sel_e;
endpackage

// File: rtl/brc_pc_sel.sv
module brc_pc_sel
   import brc_pkg::*;
#(
   parameter int unsigned AW = 32,
   parameter logic [AW-1:0] RESET_PC = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  pc_sel_e       sel_i,
   input  logic [AW-1:0] target_i,
   output logic [AW-1:0] pc_o
);
   localparam logic [AW-1:0] STEP = AW'(INSTR_BYTES);

   logic [AW-1:0] pc_q;
   logic [AW-1:0] pc_d;

   always_comb begin
      unique case (sel_i)
         SEL_TGT:  pc_d = target_i;
         SEL_HOLD: pc_d = pc_q;
         default:  pc_d = pc_q + STEP;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pc_q <= RESET_PC;
      else        pc_q <= pc_d;
   end

   assign pc_o = pc_q;
endmodule

// File: rtl/brc_flush_gen.sv
module brc_flush_gen
   import brc_pkg::*;
#(
   parameter int unsigned NF = NUM_FLUSH
) (
   input  logic          redirect_i,
   output logic [NF-1:0] flush_o
);
   for (genvar s = 0; s < NF; s++) begin : g_stage
      assign flush_o[s] = redirect_i;
   end
endmodule

// File: rtl/brc_penalty_ctr.sv
module brc_penalty_ctr #(
   parameter int unsigned CW   = 16,
   parameter int unsigned STEP = 4,
   parameter bit          SAT  = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hit_i,
   output logic [CW-1:0] count_o
);
   localparam logic [CW-1:0] INC  = CW'(STEP);
   localparam logic [CW-1:0] CMAX = '1;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_d;

   if (SAT) begin : g_sat
      always_comb begin
         if (!hit_i)                 cnt_d = cnt_q;
         else if (CMAX - cnt_q < INC) cnt_d = CMAX;
         else                         cnt_d = cnt_q + INC;
      end
   end else begin : g_wrap
      always_comb cnt_d = hit_i ? cnt_q + INC : cnt_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
   end

   assign count_o = cnt_q;
endmodule

// File: rtl/branch_redirect_ctrl.sv
module branch_redirect_ctrl
   import brc_pkg::*;
#(
   parameter int unsigned   AW       = 32,
   parameter int unsigned   CW       = 16,
   parameter bit            CNT_SAT  = 1'b0,
   parameter logic [AW-1:0] RESET_PC = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 stall_i,
   input  logic                 br_valid_i,
   input  logic                 br_taken_i,
   input  logic [AW-1:0]        br_target_i,
   output logic [AW-1:0]        pc_o,
   output logic [NUM_FLUSH-1:0] flush_o,
   output logic [CW-1:0]        penalty_o
);
   if (AW < 3) begin : g_bad_aw
      initial $error("AW too small for word increments");
   end
   if (CW < 3) begin : g_bad_cw
      initial $error("CW too small to count penalties");
   end

   logic    redirect;
   pc_sel_e sel;

   assign redirect = br_valid_i & br_taken_i;

   always_comb begin
      if (redirect)     sel = SEL_TGT;
      else if (stall_i) sel = SEL_HOLD;
      else              sel = SEL_SEQ;
   end

   brc_pc_sel #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .target_i(br_target_i), .pc_o(pc_o)
   );

   brc_flush_gen #(.NF(NUM_FLUSH)) u_flush (
      .redirect_i(redirect), .flush_o(flush_o)
   );

   brc_penalty_ctr #(.CW(CW), .STEP(NUM_FLUSH), .SAT(CNT_SAT)) u_pen (
      .clk(clk), .rst_n(rst_n), .hit_i(redirect), .count_o(penalty_o)
   );
endmodule

// File: rtl/branch_redirect_ctrl_chk.sv
module branch_redirect_ctrl_chk #(
   parameter int unsigned AW = 32,
   parameter int unsigned CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          stall_i,
   input logic          br_valid_i,
   input logic          br_taken_i,
   input logic [AW-1:0] br_target_i,
   input logic [AW-1:0] pc_o,
   input logic [3:0]    flush_o,
   input logic [CW-1:0] penalty_o
);
   assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!(br_valid_i && br_taken_i) && !stall_i) |=> pc_o == $past(pc_o) + AW'(4));

   assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(br_valid_i && br_taken_i) && stall_i) |=> $stable(pc_o));

   // R7: the redirect is checked whatever stall_i is
   assert_redirect_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid_i && br_taken_i) |=> pc_o == $past(br_target_i));

   assert_flush_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid_i && br_taken_i) |-> flush_o == 4'hF);

   assert_no_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(br_valid_i && br_taken_i) |-> flush_o == 4'h0);

   assert_penalty_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid_i && br_taken_i) |=> penalty_o == $past(penalty_o) + CW'(4));

   assert_penalty_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(br_valid_i && br_taken_i) |=> $stable(penalty_o));
endmodule

bind branch_redirect_ctrl branch_redirect_ctrl_chk #(.AW(AW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .br_valid_i(br_valid_i),
   .br_taken_i(br_taken_i), .br_target_i(br_target_i), .pc_o(pc_o),
   .flush_o(flush_o), .penalty_o(penalty_o)
);

// File: tb/test_branch_redirect_ctrl.sv
`timescale 1ns/1ps
module test_branch_redirect_ctrl;
   localparam int unsigned   AW   = 32;
   localparam int unsigned   CW   = 16;
   localparam logic [AW-1:0] RPC  = 32'h0000_1000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stall_i = 1'b0;
   logic          br_valid_i = 1'b0;
   logic          br_taken_i = 1'b0;
   logic [AW-1:0] br_target_i = '0;
   logic [AW-1:0] pc_o;
   logic [3:0]    flush_o;
   logic [CW-1:0] penalty_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [AW-1:0] m_pc;
   logic [CW-1:0] m_pen;

   always #10 clk = ~clk;

   branch_redirect_ctrl #(.AW(AW), .CW(CW), .RESET_PC(RPC)) i_branch_redirect_ctrl (
      .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .br_valid_i(br_valid_i),
      .br_taken_i(br_taken_i), .br_target_i(br_target_i), .pc_o(pc_o),
      .flush_o(flush_o), .penalty_o(penalty_o)
   );

   function automatic logic [AW-1:0] exp_pc(logic [AW-1:0] pc, logic st, logic v,
                                            logic tk, logic [AW-1:0] tg);
      if (v && tk) return tg;
      if (st)      return pc;
      return pc + AW'(4);
   endfunction

   function automatic logic [CW-1:0] exp_pen(logic [CW-1:0] p, logic v, logic tk);
      return (v && tk) ? p + CW'(4) : p;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // drive one cycle at negedge, check flush, advance model, check pc/penalty next negedge
   task automatic step(string req, logic st, logic v, logic tk, logic [AW-1:0] tg);
      stall_i = st; br_valid_i = v; br_taken_i = tk; br_target_i = tg;
      #1;
      check({req, " flush"}, 64'(flush_o), (v && tk) ? 64'hF : 64'h0);
      m_pc  = exp_pc(m_pc, st, v, tk, tg);
      m_pen = exp_pen(m_pen, v, tk);
      @(negedge clk);
      check({req, " pc"}, 64'(pc_o), 64'(m_pc));
      check({req, " penalty"}, 64'(penalty_o), 64'(m_pen));
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [AW-1:0] tg;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 pc", 64'(pc_o), 64'(RPC));
      check("R1 penalty", 64'(penalty_o), 64'h0);
      check("R1 flush", 64'(flush_o), 64'h0);
      rst_n = 1'b1;
      m_pc = RPC; m_pen = '0;

      step("R2 seq", 0, 0, 0, '0);
      step("R2 seq", 0, 0, 0, '0);
      step("R3 stall", 1, 0, 0, '0);
      step("R4 taken", 0, 1, 1, 32'h0000_2000);
      step("R6 not taken", 0, 1, 0, 32'h0000_9000);
      step("R9 taken w/o valid", 0, 0, 1, 32'h0000_7700);
      step("R9 taken w/o valid stall", 1, 0, 1, 32'h0000_7700);
      step("R7 taken over stall", 1, 1, 1, 32'h0000_4440);
      step("R8 back to back", 0, 1, 1, 32'h0000_5000);
      step("R8 back to back", 0, 1, 1, 32'h0000_6000);
      step("R5 jump near top", 0, 1, 1, 32'hFFFF_FFF8);
      step("R2 wrap", 0, 0, 0, '0);
      step("R2 wrap", 0, 0, 0, '0);

      for (int i = 0; i < 3000; i++) begin
         tg = $urandom() & 32'hFFFF_FFFC;
         step("R2-mix random", ($urandom() % 4) == 0, ($urandom() % 3) == 0,
              ($urandom() % 2) == 0, tg);
      end
      // long taken run to push the counter through a wrap (R8)
      for (int i = 0; i < 16400; i++) begin
         step("R8 wrap run", 0, 1, 1, 32'h0000_0100);
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule